// File: doc/BRIEF.md
# Page-Offset Branch Target Predictor

This block predicts where a direct branch in the fetch stream will land. Most such branches jump within the 4 KiB page that holds them, so each entry of the large main table keeps only the 12-bit in-page part of the target. On a hit, that part is appended to the page number of the fetch address. Branches that leave their page are kept in a small, fully associative side table that stores complete targets. The main entry for such a branch only records which side slot to read. A prediction from the side table costs four more cycles, and the lookup port reports busy while it is pending.

The fetch unit presents an address on the lookup port and receives a one-cycle response pulse carrying a hit flag and a target. When a branch resolves, the execution side writes the branch address and its real target on the update port. The block decides by itself which table receives the update.

Top module: `pgofs_btb`

## Requirements
- R1: After reset every lookup answers with `rsp_hit` low and `rsp_target` zero, and `busy` is low.
- R2: A lookup is accepted at a rising edge where `lk_valid` is high and `busy` is low. For an in-page hit or any miss, `rsp_valid` is high for exactly the one cycle that follows the second rising edge counted from acceptance.
- R3: If the last update of a branch had its address and target in the same page (bits [31:12] equal), a lookup of that branch hits and returns the fetch address bits [31:12] joined with the stored bits [11:0].
- R4: The main table is direct-mapped. It is indexed by address bits [12:2] and tagged with bits [20:13]. A lookup that matches the index but not the tag misses, and a newer update at the same index displaces the older branch.
- R5: A hit on a branch whose target lies in another page returns the full stored target. The response comes four cycles later than an in-page response, so `rsp_valid` follows the sixth rising edge counted from acceptance.
- R6: `busy` goes high in the cycle after a cross-page lookup is accepted and stays high until the edge that raises its `rsp_valid`.
- R7: A lookup presented while `busy` is high is dropped and yields no response.
- R8: Side-table slots are handed out round-robin over `FAR_ENTRIES`. A branch whose slot has been handed to another branch misses, with in-page latency.
- R9: Updating a cross-page branch that already owns a side slot rewrites that slot and does not advance the round-robin pointer.
- R10: An in-page update of a branch that was cross-page turns it back into an in-page entry, with in-page latency and an offset-formed target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch address to look up |
| busy | output | 1 | Cross-page prediction pending; lookups are not accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Prediction found |
| rsp_target | output | ADDR_W | Predicted target (zero on miss) |
| upd_valid | input | 1 | Resolved branch update |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
The bench instantiates the block with `FAR_ENTRIES` set to 4. All other parameters keep their defaults: 32-bit addresses, 4 KiB pages, 2048 main entries, an 8-bit tag and a four-cycle side penalty. With only four side slots, five cross-page updates are enough to force eviction. The small table also makes the difference between reusing a slot and allocating a new one visible at the lookup port. The bench measures latency in edges from acceptance, so the one-edge and five-edge response windows are checked exactly.

// File: rtl/pgofs_pkg.sv
package pgofs_pkg;
  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_PAGE_BITS = 12;
  localparam int unsigned DEF_IDX_BITS  = 11;
  localparam int unsigned DEF_TAG_BITS  = 8;
  localparam int unsigned DEF_FAR_N     = 32;
  localparam int unsigned DEF_FAR_DLY   = 4;

  // where a registered response came from
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NEAR = 2'd1,
    SRC_FAR  = 2'd2
  } rsp_src_e;
endpackage

// File: rtl/pgofs_near_ram.sv
module pgofs_near_ram #(
  parameter int unsigned IDX_BITS = 11,
  parameter int unsigned W        = 21
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_BITS-1:0] waddr,
  input  logic [W-1:0]        wdata,
  input  logic                re,
  input  logic [IDX_BITS-1:0] raddr,
  output logic [W-1:0]        rdata,
  output logic                rvld
);
  localparam int unsigned DEPTH = 1 << IDX_BITS;

  // payload kept in a plain array so it maps to block RAM
  logic [W-1:0] mem [DEPTH];
  // valid bits live in flops so reset can clear them in one cycle
  logic [DEPTH-1:0] vbits;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits <= '0;
      rvld  <= 1'b0;
    end else begin
      if (we) vbits[waddr] <= 1'b1;
      if (re) rvld <= vbits[raddr];
    end
  end
endmodule

// File: rtl/pgofs_far_table.sv
module pgofs_far_table #(
  parameter int unsigned AW    = 32,
  parameter int unsigned FAR_N = 32,
  parameter int unsigned FI    = $clog2(FAR_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_pc,
  input  logic [AW-1:0] wr_tgt,
  output logic [FI-1:0] wr_slot,
  input  logic [FI-1:0] rd_slot,
  input  logic [AW-1:0] rd_pc,
  output logic          rd_hit,
  output logic [AW-1:0] rd_tgt
);
  logic [FAR_N-1:0] fv;
  logic [AW-1:0]    fpc  [FAR_N];
  logic [AW-1:0]    ftgt [FAR_N];
  logic [FI-1:0]    ptr;
  logic [FAR_N-1:0] match;
  logic             any_match;
  logic [FI-1:0]    match_idx;

  for (genvar i = 0; i < FAR_N; i++) begin : g_cmp
    assign match[i] = fv[i] && (fpc[i] == wr_pc);
  end

  always_comb begin
    any_match = 1'b0;
    match_idx = '0;
    for (int i = FAR_N - 1; i >= 0; i--) begin
      if (match[i]) begin
        any_match = 1'b1;
        match_idx = FI'(i);
      end
    end
  end

  assign wr_slot = any_match ? match_idx : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      fv  <= '0;
      ptr <= '0;
    end else if (wr_en) begin
      fv[wr_slot] <= 1'b1;
      if (!any_match) ptr <= (ptr == FI'(FAR_N - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      fpc[wr_slot]  <= wr_pc;
      ftgt[wr_slot] <= wr_tgt;
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_tgt = '0;
    if (int'(rd_slot) < FAR_N) begin
      rd_hit = fv[rd_slot] && (fpc[rd_slot] == rd_pc);
      rd_tgt = ftgt[rd_slot];
    end
  end
endmodule

// File: rtl/pgofs_delay.sv
module pgofs_delay #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire,
  output logic busy
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= CW'(DELAY);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign fire = (cnt == CW'(1));
  assign busy = (cnt != '0);
endmodule

// File: rtl/pgofs_btb.sv
module pgofs_btb
  import pgofs_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned PAGE_BITS   = DEF_PAGE_BITS,
  parameter int unsigned IDX_BITS    = DEF_IDX_BITS,
  parameter int unsigned TAG_BITS    = DEF_TAG_BITS,
  parameter int unsigned FAR_ENTRIES = DEF_FAR_N,
  parameter int unsigned FAR_DELAY   = DEF_FAR_DLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int unsigned FI     = $clog2(FAR_ENTRIES);
  localparam int unsigned PAY    = (PAGE_BITS > FI) ? PAGE_BITS : FI;
  localparam int unsigned EW     = 1 + TAG_BITS + PAY;
  localparam int unsigned TAG_LO = IDX_BITS + 2;

  // ---------------- update path ----------------
  logic           same_pg;
  logic [FI-1:0]  far_wslot;
  logic [PAY-1:0] pay_w;
  logic [EW-1:0]  ent_w;

  assign same_pg = (upd_pc[ADDR_W-1:PAGE_BITS] == upd_target[ADDR_W-1:PAGE_BITS]);

  always_comb begin
    pay_w = '0;
    if (same_pg) pay_w[PAGE_BITS-1:0] = upd_target[PAGE_BITS-1:0];
    else         pay_w[FI-1:0]        = far_wslot;
  end

  assign ent_w = {!same_pg, upd_pc[TAG_LO +: TAG_BITS], pay_w};

  // ---------------- lookup stage 1 ----------------
  logic              take;
  logic              s1_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [EW-1:0]     rdata;
  logic              rvld;

  assign take = lk_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= take;
    if (take) s1_addr <= lk_addr;
  end

  pgofs_near_ram #(.IDX_BITS(IDX_BITS), .W(EW)) u_near (
    .clk(clk), .rst(rst),
    .we(upd_valid), .waddr(upd_pc[IDX_BITS+1:2]), .wdata(ent_w),
    .re(take), .raddr(lk_addr[IDX_BITS+1:2]),
    .rdata(rdata), .rvld(rvld)
  );

  logic                s1_far_flag;
  logic [TAG_BITS-1:0] s1_tag;
  logic [PAY-1:0]      s1_pay;
  logic                s1_hit;
  logic                s1_far;

  assign s1_far_flag = rdata[EW-1];
  assign s1_tag      = rdata[EW-2 -: TAG_BITS];
  assign s1_pay      = rdata[PAY-1:0];
  assign s1_hit      = s1_v && rvld && (s1_tag == s1_addr[TAG_LO +: TAG_BITS]);
  assign s1_far      = s1_hit && s1_far_flag;

  // ---------------- side table ----------------
  logic              far_hit;
  logic [ADDR_W-1:0] far_tgt;

  pgofs_far_table #(.AW(ADDR_W), .FAR_N(FAR_ENTRIES), .FI(FI)) u_far (
    .clk(clk), .rst(rst),
    .wr_en(upd_valid && !same_pg), .wr_pc(upd_pc), .wr_tgt(upd_target),
    .wr_slot(far_wslot),
    .rd_slot(s1_pay[FI-1:0]), .rd_pc(s1_addr),
    .rd_hit(far_hit), .rd_tgt(far_tgt)
  );

  // ---------------- penalty timer ----------------
  logic              tmr_start;
  logic              tmr_fire;
  logic              tmr_busy;
  logic [ADDR_W-1:0] hold_tgt;

  assign tmr_start = s1_far && far_hit;

  pgofs_delay #(.DELAY(FAR_DELAY)) u_dly (
    .clk(clk), .rst(rst), .start(tmr_start), .fire(tmr_fire), .busy(tmr_busy)
  );

  always_ff @(posedge clk) begin
    if (tmr_start) hold_tgt <= far_tgt;
  end

  assign busy = tmr_busy || s1_far;

  // ---------------- registered response ----------------
  rsp_src_e rsp_src;
  logic     rsp_far;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_target <= '0;
      rsp_src    <= SRC_NONE;
    end else if (tmr_fire) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= 1'b1;
      rsp_target <= hold_tgt;
      rsp_src    <= SRC_FAR;
    end else if (s1_v && !tmr_start) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= s1_hit && !s1_far_flag;
      rsp_target <= (s1_hit && !s1_far_flag) ?
                    {s1_addr[ADDR_W-1:PAGE_BITS], s1_pay[PAGE_BITS-1:0]} : '0;
      rsp_src    <= SRC_NEAR;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_target <= '0;
      rsp_src    <= SRC_NONE;
    end
  end

  assign rsp_far = (rsp_src == SRC_FAR);
endmodule

// File: rtl/pgofs_btb_chk.sv
module pgofs_btb_chk #(
  parameter int unsigned AW  = 32,
  parameter int unsigned PG  = 12,
  parameter int unsigned DLY = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic [AW-1:0] lk_addr,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic [AW-1:0] rsp_target,
  input logic          upd_valid,
  input logic          rsp_far,
  input logic          tmr_start
);
  logic       seen_upd;
  logic [7:0] far_age;

  always_ff @(posedge clk) begin
    if (rst) seen_upd <= 1'b0;
    else if (upd_valid) seen_upd <= 1'b1;
  end

  // cycles since the side-table penalty began
  always_ff @(posedge clk) begin
    if (rst)                                     far_age <= '0;
    else if (tmr_start)                          far_age <= 8'd1;
    else if (far_age != '0 && far_age != 8'hFF)  far_age <= far_age + 8'd1;
  end

  assert_miss_before_update_R1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !seen_upd) |-> (!rsp_hit && rsp_target == '0));

  assert_near_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_far) |-> $past(lk_valid && !busy, 2));

  assert_page_join_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit && !rsp_far) |->
      (rsp_target[AW-1:PG] == $past(lk_addr[AW-1:PG], 2)));

  assert_far_delay_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_far) |-> (far_age == 8'(DLY + 1)));

  assert_busy_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_valid);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_far) |-> !$past(busy, 2));
endmodule

bind pgofs_btb pgofs_btb_chk #(.AW(ADDR_W), .PG(PAGE_BITS), .DLY(FAR_DELAY)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target),
  .upd_valid(upd_valid), .rsp_far(rsp_far), .tmr_start(tmr_start)
);

// File: tb/sim_pgofs_btb.sv
module sim_pgofs_btb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        busy;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pgofs_btb #(.FAR_ENTRIES(4)) u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lk_valid = 1'b0; upd_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // lat = rising edges after the accepting edge until rsp_valid is seen
  task automatic look(input logic [31:0] a, output bit hit, output logic [31:0] tgt,
                      output int lat, output bit bsy);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    bsy = busy;
    lat = 0; hit = 1'b0; tgt = '0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (rsp_valid) begin
        lat = k; hit = rsp_hit; tgt = rsp_target;
        break;
      end
    end
  endtask

  task automatic t_reset_miss();
    bit h; logic [31:0] t; int l; bit b;
    do_reset();
    chk(busy == 1'b0 && rsp_valid == 1'b0, "R1 idle after reset", {30'd0, busy, rsp_valid}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      look(32'h0000_1100 + 32'(i) * 32'h0001_0040, h, t, l, b);
      chk(!h && t == 0, "R1 miss after reset", {31'd0, h}, 32'd0);
      chk(l == 1, "R2 miss latency", 32'(l), 32'd1);
    end
  endtask

  task automatic t_near();
    bit h; logic [31:0] t; int l; bit b;
    do_reset();
    upd(32'h0000_1100, 32'h0000_1F40);
    upd(32'h0000_7AB0, 32'h0000_7004);
    look(32'h0000_1100, h, t, l, b);
    chk(h && t == 32'h0000_1F40, "R3 in-page target", t, 32'h0000_1F40);
    chk(l == 1 && !b, "R2 in-page latency", 32'(l), 32'd1);
    look(32'h0000_7AB0, h, t, l, b);
    chk(h && t == 32'h0000_7004, "R3 second in-page target", t, 32'h0000_7004);
    // same index [12:2], tag [20:13] differs
    look(32'h0000_3100, h, t, l, b);
    chk(!h, "R4 tag mismatch misses", {31'd0, h}, 32'd0);
    upd(32'h0000_3100, 32'h0000_3008);
    look(32'h0000_1100, h, t, l, b);
    chk(!h, "R4 displaced by same index", {31'd0, h}, 32'd0);
    look(32'h0000_3100, h, t, l, b);
    chk(h && t == 32'h0000_3008, "R4 new occupant", t, 32'h0000_3008);
  endtask

  task automatic t_far();
    bit h; logic [31:0] t; int l; bit b;
    do_reset();
    upd(32'h0002_0200, 32'h0080_0010);
    look(32'h0002_0200, h, t, l, b);
    chk(h && t == 32'h0080_0010, "R5 cross-page target", t, 32'h0080_0010);
    chk(l == 5, "R5 cross-page latency", 32'(l), 32'd5);
    chk(b, "R6 busy during penalty", {31'd0, b}, 32'd1);
    chk(!busy, "R6 busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_busy_ignore();
    int nresp = 0; int at = 0; logic [31:0] got = '0;
    do_reset();
    upd(32'h0002_0200, 32'h0080_0010);
    upd(32'h0000_1100, 32'h0000_1F40);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h0002_0200;
    @(posedge clk);
    @(negedge clk);
    lk_addr = 32'h0000_1100;
    chk(busy, "R6 busy after far accept", {31'd0, busy}, 32'd1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 3) lk_valid = 1'b0;
      if (rsp_valid) begin
        nresp++; at = k; got = rsp_target;
      end
    end
    lk_valid = 1'b0;
    chk(nresp == 1, "R7 lookup during busy dropped", 32'(nresp), 32'd1);
    chk(at == 5 && got == 32'h0080_0010, "R7 only far response", got, 32'h0080_0010);
  endtask

  task automatic t_evict();
    bit h; logic [31:0] t; int l; bit b;
    do_reset();
    for (int i = 0; i < 5; i++)
      upd(32'h0002_0200 + 32'(i) * 32'h10, 32'h0090_0000 + 32'(i) * 32'h100);
    look(32'h0002_0200, h, t, l, b);
    chk(!h && l == 1, "R8 evicted slot misses", {31'd0, h}, 32'd0);
    look(32'h0002_0210, h, t, l, b);
    chk(h && t == 32'h0090_0100 && l == 5, "R8 survivor hits", t, 32'h0090_0100);
    look(32'h0002_0240, h, t, l, b);
    chk(h && t == 32'h0090_0400, "R8 newest hits", t, 32'h0090_0400);
  endtask

  task automatic t_reuse();
    bit h; logic [31:0] t; int l; bit b;
    do_reset();
    for (int i = 0; i < 3; i++)
      upd(32'h0002_0200 + 32'(i) * 32'h10, 32'h0090_0000 + 32'(i) * 32'h100);
    upd(32'h0002_0200, 32'h00A0_0000);
    upd(32'h0002_0230, 32'h0090_0300);
    look(32'h0002_0200, h, t, l, b);
    chk(h && t == 32'h00A0_0000, "R9 rewritten slot", t, 32'h00A0_0000);
    look(32'h0002_0230, h, t, l, b);
    chk(h && t == 32'h0090_0300, "R9 pointer not advanced", t, 32'h0090_0300);
    look(32'h0002_0210, h, t, l, b);
    chk(h && t == 32'h0090_0100, "R9 neighbour intact", t, 32'h0090_0100);
  endtask

  task automatic t_retarget();
    bit h; logic [31:0] t; int l; bit b;
    do_reset();
    upd(32'h0002_0200, 32'h0080_0010);
    upd(32'h0002_0200, 32'h0002_0380);
    look(32'h0002_0200, h, t, l, b);
    chk(h && t == 32'h0002_0380, "R10 back to in-page target", t, 32'h0002_0380);
    chk(l == 1 && !b, "R10 in-page latency", 32'(l), 32'd1);
  endtask

  initial begin
    t_reset_miss();
    t_near();
    t_far();
    t_busy_ignore();
    t_evict();
    t_reuse();
    t_retarget();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule